// File: doc/BRIEF.md
# Load/Store Data Size Formatter

This block sits between a register file and a 32-bit little-endian data memory port. It prepares single-register transfers of word, halfword and byte size. On a store it copies the register value onto every byte lane the access can reach and raises a write strobe for each lane that is actually written. On a load it picks the addressed byte or halfword out of the word returned by memory and widens it to 32 bits, with either zero or sign extension.

Each request carries the access size, a signed flag, a load/store flag, the two low address bits, the register value to store and the memory word read for a load. Requests and results travel on valid/ready channels. The result is held in a single output register. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. Its formatted result appears on the next cycle with `rsp_valid` high, and it stays unchanged until a rising edge where `rsp_ready` is high. A new request may be taken on the same edge that hands a result off, so back-to-back requests flow at one per cycle when the consumer never stalls.

Top module: `ls_size_fmt`

## Requirements
- R1: Size code 2'b10 or 2'b11 is a word. A word store drives strobes 4'b1111 and write data equal to the register value, whatever the address bits are.
- R2: Size code 2'b00 is a byte. A byte store drives strobe 4'b0001 shifted left by address bits [1:0]. The write data is bits [7:0] of the register value, repeated on all four lanes.
- R3: Size code 2'b01 is a halfword. A halfword store drives strobe 4'b0011 shifted left by twice address bit [1], and address bit [0] is ignored. The write data is bits [15:0] of the register value, repeated in both halves.
- R4: The signed flag has no effect on stores or on word loads.
- R5: A byte load takes bits [8*a+7:8*a] of the read word, where a is address bits [1:0]. If the signed flag is 0, the upper 24 bits of the result are zero.
- R6: If the signed flag is 1, a byte or halfword load fills the upper bits of the result with the top bit of the selected value.
- R7: A halfword load takes bits [15:0] of the read word when address bit [1] is 0, and bits [31:16] when it is 1. Address bit [0] is ignored.
- R8: A word load returns the read word unchanged.
- R9: A load (load flag 1) drives strobes 4'b0000 and write data of zero. A store drives a load result of zero.
- R10: A request is taken on a rising edge where `req_valid` and `req_ready` are both high. Its result appears with `rsp_valid` high on the next cycle. While `rsp_valid` is high and `rsp_ready` is low, the result and `rsp_valid` stay unchanged.
- R11: `req_ready` equals (not `rsp_valid`) or `rsp_ready`.
- R12: While reset is held, and right after it, `rsp_valid` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | The request is taken on this edge if valid |
| req_is_load | input | 1 | 1 = load, 0 = store |
| req_signed | input | 1 | Sign-extend a byte or halfword load |
| req_size | input | 2 | 00 byte, 01 halfword, 1x word |
| req_addr_lo | input | 2 | Low address bits of the access |
| req_wdata | input | 32 | Register value to store |
| req_rdata | input | 32 | Word read from memory for a load |
| rsp_valid | output | 1 | A formatted result is presented |
| rsp_ready | input | 1 | The consumer takes the result |
| rsp_wstrb | output | 4 | Per-byte write strobes, bit i = lane i |
| rsp_wdata | output | 32 | Write data with lanes replicated |
| rsp_ldata | output | 32 | Extended load result |

## Verification
Two things can happen on the same rising edge: the held result is handed to the consumer, and a new request is taken into the register it leaves. The bench provokes this by holding requests back to back while `rsp_ready` follows a fixed stall pattern. Each stall freezes the output register, and each release both drains it and refills it. A scoreboard queue, filled in order of acceptance, must then match every presented result, including the repeated views of a stalled one. The bench also checks `req_ready` against the output state on every offered cycle.

// File: rtl/ls_size_fmt_pkg.sv
package ls_size_fmt_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_WALT = 2'b11
  } xfer_size_e;
endpackage

// File: rtl/ls_size_fmt_store.sv
module ls_size_fmt_store
  import ls_size_fmt_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [1:0]                     size,
  input  logic [$clog2(DATA_W/8)-1:0]    off,
  input  logic [DATA_W-1:0]              src,
  output logic [DATA_W/8-1:0]            strb,
  output logic [DATA_W-1:0]              data
);
  localparam int LANES = DATA_W / 8;
  localparam int OFF_W = $clog2(LANES);

  logic [DATA_W-1:0] byte_rep;
  logic [DATA_W-1:0] half_rep;
  logic [LANES-1:0]  byte_strb;
  logic [LANES-1:0]  half_strb;
  logic [OFF_W-1:0]  half_off;

  // copy the low byte / low halfword onto every lane
  for (genvar g = 0; g < LANES; g++) begin : g_rep
    assign byte_rep[8*g +: 8] = src[7:0];
    assign half_rep[8*g +: 8] = src[8*(g % 2) +: 8];
  end

  assign half_off  = {off[OFF_W-1:1], 1'b0};
  assign byte_strb = LANES'(1) << off;
  assign half_strb = LANES'(3) << half_off;

  always_comb begin
    case (xfer_size_e'(size))
      SZ_BYTE: begin
        strb = byte_strb;
        data = byte_rep;
      end
      SZ_HALF: begin
        strb = half_strb;
        data = half_rep;
      end
      default: begin
        strb = '1;
        data = src;
      end
    endcase
  end
endmodule

// File: rtl/ls_size_fmt_load.sv
module ls_size_fmt_load
  import ls_size_fmt_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [1:0]                  size,
  input  logic                        sgn,
  input  logic [$clog2(DATA_W/8)-1:0] off,
  input  logic [DATA_W-1:0]           src,
  output logic [DATA_W-1:0]           res
);
  localparam int LANES = DATA_W / 8;
  localparam int OFF_W = $clog2(LANES);
  localparam int SH_W  = OFF_W + 3;

  logic [SH_W-1:0]   byte_sh;
  logic [SH_W-1:0]   half_sh;
  logic [DATA_W-1:0] byte_aligned;
  logic [DATA_W-1:0] half_aligned;
  logic [7:0]        b_val;
  logic [15:0]       h_val;

  assign byte_sh      = {off, 3'b000};
  assign half_sh      = {off[OFF_W-1:1], 4'b0000};
  assign byte_aligned = src >> byte_sh;
  assign half_aligned = src >> half_sh;
  assign b_val        = byte_aligned[7:0];
  assign h_val        = half_aligned[15:0];

  always_comb begin
    case (xfer_size_e'(size))
      SZ_BYTE: res = {{(DATA_W-8){sgn & b_val[7]}}, b_val};
      SZ_HALF: res = {{(DATA_W-16){sgn & h_val[15]}}, h_val};
      default: res = src;
    endcase
  end
endmodule

// File: rtl/ls_size_fmt_pipe.sv
module ls_size_fmt_pipe #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end
endmodule

// File: rtl/ls_size_fmt.sv
module ls_size_fmt #(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_is_load,
  input  logic                req_signed,
  input  logic [1:0]          req_size,
  input  logic [1:0]          req_addr_lo,
  input  logic [DATA_W-1:0]   req_wdata,
  input  logic [DATA_W-1:0]   req_rdata,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [DATA_W/8-1:0] rsp_wstrb,
  output logic [DATA_W-1:0]   rsp_wdata,
  output logic [DATA_W-1:0]   rsp_ldata
);
  localparam int LANES = DATA_W / 8;
  localparam int OFF_W = $clog2(LANES);
  localparam int PAY_W = LANES + 2 * DATA_W;

  logic [OFF_W-1:0]  off;
  logic [LANES-1:0]  st_strb;
  logic [DATA_W-1:0] st_data;
  logic [DATA_W-1:0] ld_res;
  logic [PAY_W-1:0]  pay_in;
  logic [PAY_W-1:0]  pay_out;

  assign off = OFF_W'(req_addr_lo);

  ls_size_fmt_store #(.DATA_W(DATA_W)) store_i (
    .size (req_size),
    .off  (off),
    .src  (req_wdata),
    .strb (st_strb),
    .data (st_data)
  );

  ls_size_fmt_load #(.DATA_W(DATA_W)) load_i (
    .size (req_size),
    .sgn  (req_signed),
    .off  (off),
    .src  (req_rdata),
    .res  (ld_res)
  );

  // the unused half of each transfer is driven to zero
  assign pay_in = req_is_load ? {{LANES{1'b0}}, {DATA_W{1'b0}}, ld_res}
                              : {st_strb, st_data, {DATA_W{1'b0}}};

  ls_size_fmt_pipe #(.W(PAY_W)) pipe_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (req_valid),
    .in_ready  (req_ready),
    .in_data   (pay_in),
    .out_valid (rsp_valid),
    .out_ready (rsp_ready),
    .out_data  (pay_out)
  );

  assign rsp_wstrb = pay_out[PAY_W-1 -: LANES];
  assign rsp_wdata = pay_out[2*DATA_W-1 -: DATA_W];
  assign rsp_ldata = pay_out[DATA_W-1:0];
endmodule

// File: rtl/ls_size_fmt_chk.sv
module ls_size_fmt_chk #(
  parameter int DATA_W = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic                req_ready,
  input logic                req_is_load,
  input logic                req_signed,
  input logic [1:0]          req_size,
  input logic [DATA_W-1:0]   req_wdata,
  input logic                rsp_valid,
  input logic                rsp_ready,
  input logic [DATA_W/8-1:0] rsp_wstrb,
  input logic [DATA_W-1:0]   rsp_wdata,
  input logic [DATA_W-1:0]   rsp_ldata
);
  logic take;
  assign take = req_valid && req_ready;

  // R10: accepted request shows up on the next cycle
  p_take_shows_r10: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> rsp_valid);

  // R10: a stalled result stays put
  p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_wstrb)
      && $stable(rsp_wdata) && $stable(rsp_ldata)));

  // R11: an empty output register always takes a request
  p_empty_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> req_ready);

  // R9: loads raise no strobe and drive no write data
  p_load_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (take && req_is_load) |=> (rsp_wstrb == '0 && rsp_wdata == '0));

  // R1: word store writes every lane with the register value
  p_word_store_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !req_is_load && req_size[1])
      |=> (rsp_wstrb == '1 && rsp_wdata == $past(req_wdata)));

  // R2 R3: store strobes are one, two or all lanes
  p_store_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !req_is_load) |=> ($countones(rsp_wstrb) == 1
      || $countones(rsp_wstrb) == 2 || rsp_wstrb == '1));

  // R6: signed byte load replicates bit 7 upward
  p_sext_byte_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && req_is_load && req_signed && req_size == 2'b00)
      |=> (rsp_ldata[DATA_W-1:8] == {(DATA_W-8){rsp_ldata[7]}}));

  // R5: unsigned byte load has zero upper bits
  p_zext_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && req_is_load && !req_signed && req_size == 2'b00)
      |=> (rsp_ldata[DATA_W-1:8] == '0));

  // R12: nothing is presented while reset is held
  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_idle_r12: assert (!rsp_valid);
    end
  end
endmodule

bind ls_size_fmt ls_size_fmt_chk #(.DATA_W(DATA_W)) chk_i (.*);

// File: tb/ls_size_fmt_tb_top.sv
module ls_size_fmt_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_is_load = 1'b0;
  logic        req_signed = 1'b0;
  logic [1:0]  req_size = 2'b00;
  logic [1:0]  req_addr_lo = 2'b00;
  logic [31:0] req_wdata = '0;
  logic [31:0] req_rdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [3:0]  rsp_wstrb;
  logic [31:0] rsp_wdata;
  logic [31:0] rsp_ldata;

  always #5 clk = ~clk;

  ls_size_fmt dut_i (.*);

  typedef struct {
    logic [3:0]  strb;
    logic [31:0] wdata;
    logic [31:0] ldata;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  int   cyc   = 0;
  bit   stall_on = 1'b0;
  bit   finished = 1'b0;

  function automatic exp_t model(bit ld, bit sg, logic [1:0] sz, logic [1:0] a,
                                 logic [31:0] wd, logic [31:0] rd, string tag);
    exp_t e;
    logic [7:0]  b;
    logic [15:0] h;
    e.tag = tag; e.strb = 4'b0; e.wdata = '0; e.ldata = '0;
    if (!ld) begin
      if (sz == 2'b00) begin
        e.strb[a] = 1'b1;
        for (int i = 0; i < 4; i++) e.wdata[8*i +: 8] = wd[7:0];
      end else if (sz == 2'b01) begin
        e.strb[{a[1], 1'b0}] = 1'b1;
        e.strb[{a[1], 1'b1}] = 1'b1;
        for (int i = 0; i < 2; i++) e.wdata[16*i +: 16] = wd[15:0];
      end else begin
        e.strb = 4'hF;
        e.wdata = wd;
      end
    end else begin
      if (sz == 2'b00) begin
        b = rd[8*a +: 8];
        e.ldata = {{24{sg && b[7]}}, b};
      end else if (sz == 2'b01) begin
        h = rd[16*a[1] +: 16];
        e.ldata = {{16{sg && h[15]}}, h};
      end else begin
        e.ldata = rd;
      end
    end
    return e;
  endfunction

  task automatic check(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic send(bit ld, bit sg, logic [1:0] sz, logic [1:0] a,
                      logic [31:0] wd, logic [31:0] rd, string tag);
    @(negedge clk);
    req_valid = 1'b1; req_is_load = ld; req_signed = sg; req_size = sz;
    req_addr_lo = a; req_wdata = wd; req_rdata = rd;
    #1;
    check(req_ready == (!rsp_valid || rsp_ready), "R11", "req_ready",
          64'(req_ready), 64'(!rsp_valid || rsp_ready));
    while (!req_ready) begin
      @(negedge clk); #1;
      check(req_ready == (!rsp_valid || rsp_ready), "R11", "req_ready",
            64'(req_ready), 64'(!rsp_valid || rsp_ready));
    end
    exp_q.push_back(model(ld, sg, sz, a, wd, rd, tag));
    @(posedge clk);
  endtask

  // monitor: compares presented results against the scoreboard head
  initial begin
    forever begin
      @(negedge clk);
      rsp_ready = stall_on ? (cyc % 3 != 2) : 1'b1;
      cyc++;
      #2;
      if (rst_n && rsp_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R10", "unexpected result", 64'(rsp_wstrb), 64'(0));
        end else begin
          check(rsp_wstrb == exp_q[0].strb, exp_q[0].tag, "strobe",
                64'(rsp_wstrb), 64'(exp_q[0].strb));
          check(rsp_wdata == exp_q[0].wdata, exp_q[0].tag, "wdata",
                64'(rsp_wdata), 64'(exp_q[0].wdata));
          check(rsp_ldata == exp_q[0].ldata, exp_q[0].tag, "ldata",
                64'(rsp_ldata), 64'(exp_q[0].ldata));
          if (rsp_ready) void'(exp_q.pop_front());
        end
      end
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "R10", "watchdog expired", 64'(exp_q.size()), 64'(0));
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(rsp_valid == 1'b0, "R12", "rsp_valid in reset", 64'(rsp_valid), 64'(0));
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(rsp_valid == 1'b0, "R12", "rsp_valid after reset", 64'(rsp_valid), 64'(0));
    check(req_ready == 1'b1, "R12", "req_ready after reset", 64'(req_ready), 64'(1));

    // stores, no back-pressure
    send(0, 0, 2'b10, 2'b11, 32'hA1B2C3D4, 32'h0, "R1");
    send(0, 0, 2'b11, 2'b01, 32'h01234567, 32'h0, "R1");
    for (int a = 0; a < 4; a++)
      send(0, 0, 2'b00, 2'(a), 32'h1122335A + 32'(a), 32'h0, "R2");
    for (int a = 0; a < 4; a++)
      send(0, 0, 2'b01, 2'(a), 32'hDEAD8001 + 32'(a), 32'h0, "R3");
    send(0, 1, 2'b00, 2'b10, 32'h000000F0, 32'h0, "R4");
    send(0, 1, 2'b01, 2'b01, 32'h0000FEDC, 32'h0, "R4");
    send(0, 1, 2'b10, 2'b00, 32'h87654321, 32'h0, "R4");

    // loads, with a stall pattern so handoff and intake share edges
    stall_on = 1'b1;
    for (int a = 0; a < 4; a++)
      send(1, 0, 2'b00, 2'(a), 32'hFFFF_FFFF, 32'h8C7B6A59, "R5");
    for (int a = 0; a < 4; a++)
      send(1, 1, 2'b00, 2'(a), 32'h0, 32'h8C7B6A59, "R6");
    for (int a = 0; a < 4; a++)
      send(1, 0, 2'b01, 2'(a), 32'h0, 32'h9ABC1357, "R7");
    for (int a = 0; a < 4; a++)
      send(1, 1, 2'b01, 2'(a), 32'h0, 32'h9ABC7357, "R6");
    send(1, 0, 2'b10, 2'b01, 32'h0, 32'hF00DCAFE, "R8");
    send(1, 1, 2'b11, 2'b11, 32'h0, 32'h80000001, "R4");
    send(0, 0, 2'b00, 2'b11, 32'h000000AB, 32'hFFFFFFFF, "R9");
    send(1, 0, 2'b10, 2'b00, 32'hFFFFFFFF, 32'h00000042, "R9");
    @(negedge clk);
    req_valid = 1'b0;

    repeat (20) @(posedge clk);
    check(exp_q.size() == 0, "R10", "scoreboard drained", 64'(exp_q.size()), 64'(0));
    summary();
  end
endmodule